// File: doc/BRIEF.md
# Serial Controller Host Register Bank

This block is the register file that a host processor sees on a 16550-compatible serial controller. A byte-wide port with a 3-bit offset reaches the settings that it keeps: interrupt enables, line format, modem control, the 16-bit baud divisor and the FIFO options. The same port also reads back the interrupt identity, the line status and the modem status. These read values are built from status inputs that the receive path, the transmit path and the modem pins supply.

The shift registers, the FIFOs and the baud generator sit outside the block. It drives them with single-cycle strobes (push a byte to transmit, pop the received byte, flush either FIFO) and with level outputs (line format, divisor, FIFO enable, receive trigger level). Status comes back as levels (data ready, holding register empty, transmitter idle, FIFO error, trigger reached) and as one-cycle error pulses. The block also produces the host interrupt, gated by the OUT2 bit of modem control, and the internal loopback of the modem-control bits onto modem status.

Top module: `uart_regbank`

## Requirements
- R1: After a synchronous reset the interrupt enables, line control, modem control and divisor are all zero. IIR reads 0x01. With the holding register empty, the transmitter idle and no other status, LSR reads 0x60. `irq` is low.
- R2: The offset map is as follows. 0 is receive byte (read) or transmit byte (write), 1 is interrupt enable, 2 is IIR (read) or FIFO control (write), 3 is line control, 4 is modem control (bits 4:0), 5 is LSR and 6 is MSR. Offset 7 reads 0. Read data appears on `rdata` in the cycle after `rd_en`. Line control reads back all 8 bits and drives `line_cfg`.
- R3: While line-control bit 7 is 1, offsets 0 and 1 read and write the low and high divisor bytes, and a write to offset 0 pushes nothing.
- R4: Only interrupt-enable bits 3:0 are stored. Writing 0xFF reads back 0x0F. The bits are 0 rx data, 1 holding register empty, 2 line status and 3 modem status.
- R5: A write to offset 0 with divisor access off pulses `tx_push` for one cycle, with the byte on `tx_data`. A read of offset 0 with divisor access off pulses `rx_pop`.
- R6: In a FIFO-control write, bit 0 sets `fifo_en` and bits 7:6 set `rx_trig`. Bits 1 and 2 give one-cycle `rx_flush` and `tx_flush` pulses and are not stored. While `fifo_en` is 1, IIR bits 7:6 read 11.
- R7: LSR bit 0 is rx data valid and bits 4:1 are overrun, parity, framing and break. Bit 5 is holding register empty, bit 6 is transmitter idle, and bit 7 is the FIFO error (only while FIFOs are enabled). Bits 4:1 hold until an LSR read clears them, and an error pulse in the cycle of that read is kept.
- R8: IIR bit 0 is 1 when nothing is pending. Bits 2:1 give the highest enabled pending source, in this priority: 11 line error, 10 rx data, 01 holding register empty, 00 modem change. The rx data source is `rx_valid` with FIFOs off and `rx_trig_hit` with FIFOs on.
- R9: The holding-register-empty source is set when `tx_hold_empty` rises, or when enable bit 1 is written from 0 to 1 while the register is empty. It is cleared by a transmit write or by an IIR read that reported code 01.
- R10: MSR bits 7:4 are DCD, RI, DSR, CTS. Bits 3:0 are change flags: DCD change, RI falling edge, DSR change, CTS change. An MSR read clears the flags, and a change in the cycle of that read is kept.
- R11: With modem-control bit 4 set, the RTS, DTR, OUT1 and OUT2 bits feed CTS, DSR, RI and DCD, and the external modem outputs are driven 0. Writing 0x1A then makes MSR read 0x90.
- R12: `irq` is registered and equals OUT2 (modem-control bit 3) AND any pending source, one cycle late.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 3 | Register offset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| rx_byte | input | 8 | Byte at head of receive path |
| rx_valid | input | 1 | Received data available |
| rx_trig_hit | input | 1 | Receive FIFO at trigger level |
| rx_overrun | input | 1 | Overrun pulse |
| rx_parity_err | input | 1 | Parity error pulse |
| rx_frame_err | input | 1 | Framing error pulse |
| rx_break | input | 1 | Break pulse |
| rx_fifo_err | input | 1 | Error present in receive FIFO |
| tx_hold_empty | input | 1 | Transmit holding register empty |
| tx_idle | input | 1 | Transmitter fully idle |
| cts_in | input | 1 | Clear to send, active high |
| dsr_in | input | 1 | Data set ready, active high |
| ri_in | input | 1 | Ring indicator, active high |
| dcd_in | input | 1 | Carrier detect, active high |
| tx_push | output | 1 | Transmit byte strobe |
| tx_data | output | 8 | Transmit byte |
| rx_pop | output | 1 | Receive byte consumed strobe |
| rx_flush | output | 1 | Receive FIFO flush strobe |
| tx_flush | output | 1 | Transmit FIFO flush strobe |
| fifo_en | output | 1 | FIFOs enabled |
| rx_trig | output | 2 | Receive trigger code (1/4/8/14 bytes) |
| line_cfg | output | 8 | Line control value |
| divisor | output | 16 | Baud divisor (clock / (16 x baud)) |
| dtr_out | output | 1 | DTR, 0 in loopback |
| rts_out | output | 1 | RTS, 0 in loopback |
| out1_out | output | 1 | OUT1, 0 in loopback |
| out2_out | output | 1 | OUT2, 0 in loopback |
| irq | output | 1 | Host interrupt |

## Verification
Two pairs of functions can land in the same cycle. An LSR read can coincide with a new error pulse, and an MSR read can coincide with a fresh modem-status change. The bench raises a framing pulse in the very cycle it reads LSR, and it reads MSR in the cycle right after entering loopback. In each case the returned byte must show the state from before the event, and the next read must show the newly captured flag, which a third read then clears.

// File: rtl/uart_rb_pkg.sv
package uart_rb_pkg;
  localparam int unsigned OFS_W = 3;
  localparam logic [OFS_W-1:0] OFS_DATA = 3'd0;
  localparam logic [OFS_W-1:0] OFS_IER  = 3'd1;
  localparam logic [OFS_W-1:0] OFS_IIR  = 3'd2;
  localparam logic [OFS_W-1:0] OFS_LCR  = 3'd3;
  localparam logic [OFS_W-1:0] OFS_MCR  = 3'd4;
  localparam logic [OFS_W-1:0] OFS_LSR  = 3'd5;
  localparam logic [OFS_W-1:0] OFS_MSR  = 3'd6;

  localparam int unsigned DIVACC_BIT = 7;
  localparam int unsigned LOOP_BIT   = 4;
  localparam int unsigned OUT2_BIT   = 3;

  typedef enum logic [1:0] {
    SRC_MODEM  = 2'b00,
    SRC_THRE   = 2'b01,
    SRC_RXDATA = 2'b10,
    SRC_LINE   = 2'b11
  } irq_src_e;
endpackage

// File: rtl/uart_rb_cfg.sv
module uart_rb_cfg
  import uart_rb_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic [OFS_W-1:0]      addr,
  input  logic [DATA_W-1:0]     wdata,
  output logic [3:0]            ier_q,
  output logic [7:0]            lcr_q,
  output logic [4:0]            mcr_q,
  output logic [2*DATA_W-1:0]   dl_q,
  output logic                  fifo_en,
  output logic [1:0]            rx_trig,
  output logic                  tx_push,
  output logic [DATA_W-1:0]     tx_data,
  output logic                  rx_pop,
  output logic                  rx_flush,
  output logic                  tx_flush,
  output logic                  thre_arm
);
  localparam int DIV_W = 2 * DATA_W;

  logic divacc;
  assign divacc = lcr_q[DIVACC_BIT];

  // enable bit 1 going 0 -> 1 re-arms the holding-empty source
  assign thre_arm = wr_en && (addr == OFS_IER) && !divacc && wdata[1] && !ier_q[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      ier_q    <= '0;
      lcr_q    <= '0;
      mcr_q    <= '0;
      dl_q     <= '0;
      fifo_en  <= 1'b0;
      rx_trig  <= '0;
      tx_push  <= 1'b0;
      tx_data  <= '0;
      rx_pop   <= 1'b0;
      rx_flush <= 1'b0;
      tx_flush <= 1'b0;
    end else begin
      tx_push  <= 1'b0;
      rx_flush <= 1'b0;
      tx_flush <= 1'b0;
      rx_pop   <= rd_en && (addr == OFS_DATA) && !divacc;
      if (wr_en) begin
        case (addr)
          OFS_DATA: begin
            if (divacc) dl_q[DATA_W-1:0] <= wdata;
            else begin
              tx_push <= 1'b1;
              tx_data <= wdata;
            end
          end
          OFS_IER: begin
            if (divacc) dl_q[DIV_W-1:DATA_W] <= wdata;
            else        ier_q <= wdata[3:0];
          end
          OFS_IIR: begin
            fifo_en  <= wdata[0];
            rx_flush <= wdata[1];
            tx_flush <= wdata[2];
            rx_trig  <= wdata[7:6];
          end
          OFS_LCR: lcr_q <= wdata[7:0];
          OFS_MCR: mcr_q <= wdata[4:0];
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_rb_status.sv
module uart_rb_status
  import uart_rb_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       lsr_rd,
  input  logic       msr_rd,
  input  logic       thre_clr,
  input  logic       thre_arm,
  input  logic [3:0] err_in,     // {break, framing, parity, overrun}
  input  logic       tx_hold_empty,
  input  logic [3:0] modem_in,   // {dcd, ri, dsr, cts}
  input  logic [4:0] mcr_q,
  output logic [3:0] lsr_err,
  output logic       thre_flag,
  output logic [7:0] msr_val
);
  logic       hold_prev;
  logic [3:0] msr_src, msr_q, delta, chg;

  // loopback: OUT2->DCD, OUT1->RI, DTR->DSR, RTS->CTS
  assign msr_src = mcr_q[LOOP_BIT] ? {mcr_q[3], mcr_q[2], mcr_q[0], mcr_q[1]} : modem_in;
  assign chg     = {msr_src[3] ^ msr_q[3], msr_q[2] & ~msr_src[2],
                    msr_src[1] ^ msr_q[1], msr_src[0] ^ msr_q[0]};
  assign msr_val = {msr_src, delta};

  always_ff @(posedge clk) begin
    if (rst) begin
      lsr_err   <= '0;
      thre_flag <= 1'b0;
      hold_prev <= 1'b1;
      msr_q     <= msr_src;
      delta     <= '0;
    end else begin
      // new events win over a clear in the same cycle
      lsr_err   <= (lsr_rd ? 4'h0 : lsr_err) | err_in;
      hold_prev <= tx_hold_empty;
      thre_flag <= (thre_flag & ~thre_clr)
                 | (tx_hold_empty & ~hold_prev)
                 | (thre_arm & tx_hold_empty);
      msr_q     <= msr_src;
      delta     <= (msr_rd ? 4'h0 : delta) | chg;
    end
  end
endmodule

// File: rtl/uart_rb_irq.sv
module uart_rb_irq
  import uart_rb_pkg::*;
(
  input  logic [3:0] ier_q,
  input  logic [3:0] lsr_err,
  input  logic       rx_src,
  input  logic       thre_flag,
  input  logic [3:0] msr_delta,
  output logic       pend,
  output irq_src_e   src_id
);
  logic want_line, want_rx, want_thre, want_modem;

  assign want_line  = ier_q[2] & (|lsr_err);
  assign want_rx    = ier_q[0] & rx_src;
  assign want_thre  = ier_q[1] & thre_flag;
  assign want_modem = ier_q[3] & (|msr_delta);

  always_comb begin
    pend   = 1'b1;
    src_id = SRC_MODEM;
    if (want_line)       src_id = SRC_LINE;
    else if (want_rx)    src_id = SRC_RXDATA;
    else if (want_thre)  src_id = SRC_THRE;
    else if (want_modem) src_id = SRC_MODEM;
    else                 pend   = 1'b0;
  end
endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
  import uart_rb_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [2:0]          addr,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [DATA_W-1:0]   wdata,
  output logic [DATA_W-1:0]   rdata,
  input  logic [DATA_W-1:0]   rx_byte,
  input  logic                rx_valid,
  input  logic                rx_trig_hit,
  input  logic                rx_overrun,
  input  logic                rx_parity_err,
  input  logic                rx_frame_err,
  input  logic                rx_break,
  input  logic                rx_fifo_err,
  input  logic                tx_hold_empty,
  input  logic                tx_idle,
  input  logic                cts_in,
  input  logic                dsr_in,
  input  logic                ri_in,
  input  logic                dcd_in,
  output logic                tx_push,
  output logic [DATA_W-1:0]   tx_data,
  output logic                rx_pop,
  output logic                rx_flush,
  output logic                tx_flush,
  output logic                fifo_en,
  output logic [1:0]          rx_trig,
  output logic [7:0]          line_cfg,
  output logic [2*DATA_W-1:0] divisor,
  output logic                dtr_out,
  output logic                rts_out,
  output logic                out1_out,
  output logic                out2_out,
  output logic                irq
);
  localparam int DIV_W = 2 * DATA_W;

  logic [3:0]       ier_q;
  logic [7:0]       lcr_q;
  logic [4:0]       mcr_q;
  logic [DIV_W-1:0] dl_q;
  logic             thre_arm, thre_flag, pend, divacc, loop_on;
  logic             iir_thre_rd, thre_clr;
  logic [3:0]       lsr_err;
  logic [7:0]       msr_val, lsr_val, iir_val;
  logic [DATA_W-1:0] rd_val;
  irq_src_e         src_id;

  uart_rb_cfg #(.DATA_W(DATA_W)) u_cfg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .ier_q(ier_q), .lcr_q(lcr_q), .mcr_q(mcr_q), .dl_q(dl_q),
    .fifo_en(fifo_en), .rx_trig(rx_trig), .tx_push(tx_push), .tx_data(tx_data),
    .rx_pop(rx_pop), .rx_flush(rx_flush), .tx_flush(tx_flush), .thre_arm(thre_arm)
  );

  assign divacc      = lcr_q[DIVACC_BIT];
  assign loop_on     = mcr_q[LOOP_BIT];
  assign iir_thre_rd = rd_en && (addr == OFS_IIR) && pend && (src_id == SRC_THRE);
  assign thre_clr    = iir_thre_rd || (wr_en && (addr == OFS_DATA) && !divacc);

  uart_rb_status u_stat (
    .clk(clk), .rst(rst),
    .lsr_rd(rd_en && (addr == OFS_LSR)),
    .msr_rd(rd_en && (addr == OFS_MSR)),
    .thre_clr(thre_clr), .thre_arm(thre_arm),
    .err_in({rx_break, rx_frame_err, rx_parity_err, rx_overrun}),
    .tx_hold_empty(tx_hold_empty),
    .modem_in({dcd_in, ri_in, dsr_in, cts_in}),
    .mcr_q(mcr_q), .lsr_err(lsr_err), .thre_flag(thre_flag), .msr_val(msr_val)
  );

  uart_rb_irq u_irq (
    .ier_q(ier_q), .lsr_err(lsr_err),
    .rx_src(fifo_en ? rx_trig_hit : rx_valid),
    .thre_flag(thre_flag), .msr_delta(msr_val[3:0]),
    .pend(pend), .src_id(src_id)
  );

  assign lsr_val = {fifo_en & rx_fifo_err, tx_idle, tx_hold_empty, lsr_err, rx_valid};
  assign iir_val = {fifo_en, fifo_en, 3'b000, src_id, ~pend};

  always_comb begin
    case (addr)
      OFS_DATA: rd_val = divacc ? dl_q[DATA_W-1:0] : rx_byte;
      OFS_IER:  rd_val = divacc ? dl_q[DIV_W-1:DATA_W] : DATA_W'(ier_q);
      OFS_IIR:  rd_val = DATA_W'(iir_val);
      OFS_LCR:  rd_val = DATA_W'(lcr_q);
      OFS_MCR:  rd_val = DATA_W'(mcr_q);
      OFS_LSR:  rd_val = DATA_W'(lsr_val);
      OFS_MSR:  rd_val = DATA_W'(msr_val);
      default:  rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
      irq   <= 1'b0;
    end else begin
      if (rd_en) rdata <= rd_val;
      irq <= mcr_q[OUT2_BIT] & pend;
    end
  end

  assign line_cfg = lcr_q;
  assign divisor  = dl_q;
  assign dtr_out  = mcr_q[0] & ~loop_on;
  assign rts_out  = mcr_q[1] & ~loop_on;
  assign out1_out = mcr_q[2] & ~loop_on;
  assign out2_out = mcr_q[3] & ~loop_on;
endmodule

// File: rtl/uart_regbank_chk.sv
module uart_regbank_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [2:0]        addr,
  input logic              wr_en,
  input logic              rd_en,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic              tx_push,
  input logic [DATA_W-1:0] tx_data,
  input logic              rx_flush,
  input logic              irq,
  input logic [4:0]        mcr_q,
  input logic [7:0]        lcr_q,
  input logic [3:0]        lsr_err,
  input logic              rx_overrun,
  input logic              rx_parity_err,
  input logic              rx_frame_err,
  input logic              rx_break
);
  p_irq_gate_r12: assert property (@(posedge clk) disable iff (rst)
    !mcr_q[3] |=> !irq);

  p_tx_push_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 3'd0 && !lcr_q[7]) |=> (tx_push && tx_data == $past(wdata)));

  p_divacc_no_push_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 3'd0 && lcr_q[7]) |=> !tx_push);

  p_flush_origin_r6: assert property (@(posedge clk) disable iff (rst)
    rx_flush |-> $past(wr_en && addr == 3'd2 && wdata[1]));

  p_ier_upper_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == 3'd1 && !lcr_q[7]) |=> (rdata[7:4] == 4'h0));

  p_lsr_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == 3'd5 && !(rx_overrun || rx_parity_err || rx_frame_err || rx_break))
      |=> (lsr_err == 4'h0));

  p_loop_map_r11: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == 3'd6 && mcr_q[4])
      |=> (rdata[7:4] == {$past(mcr_q[3]), $past(mcr_q[2]), $past(mcr_q[0]), $past(mcr_q[1])}));
endmodule

bind uart_regbank uart_regbank_chk u_chk (.*);

// File: tb/uart_regbank_test.sv
module uart_regbank_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 21;
  // {is_read, offset, write data, expected read}
  localparam logic [19:0] VEC [NV] = '{
    {1'b0, 3'd3, 8'h80, 8'h00}, {1'b0, 3'd0, 8'h0C, 8'h00}, {1'b0, 3'd1, 8'h01, 8'h00},
    {1'b1, 3'd0, 8'h00, 8'h0C}, {1'b1, 3'd1, 8'h00, 8'h01}, {1'b0, 3'd3, 8'h1B, 8'h00},
    {1'b1, 3'd3, 8'h00, 8'h1B}, {1'b1, 3'd1, 8'h00, 8'h00}, {1'b0, 3'd1, 8'hFF, 8'h00},
    {1'b1, 3'd1, 8'h00, 8'h0F}, {1'b1, 3'd2, 8'h00, 8'h02}, {1'b1, 3'd2, 8'h00, 8'h01},
    {1'b0, 3'd1, 8'h00, 8'h00}, {1'b0, 3'd4, 8'h03, 8'h00}, {1'b1, 3'd4, 8'h00, 8'h03},
    {1'b0, 3'd2, 8'hC1, 8'h00}, {1'b1, 3'd2, 8'h00, 8'hC1}, {1'b0, 3'd2, 8'h00, 8'h00},
    {1'b1, 3'd2, 8'h00, 8'h01}, {1'b1, 3'd7, 8'h00, 8'h00}, {1'b1, 3'd5, 8'h00, 8'h60}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic [2:0] addr = '0;
  logic wr_en = 0, rd_en = 0;
  logic [7:0] wdata = '0, rdata, rx_byte = 8'hA5;
  logic rx_valid = 0, rx_trig_hit = 0, rx_overrun = 0, rx_parity_err = 0;
  logic rx_frame_err = 0, rx_break = 0, rx_fifo_err = 0;
  logic tx_hold_empty = 1, tx_idle = 1;
  logic cts_in = 0, dsr_in = 0, ri_in = 0, dcd_in = 0;
  logic tx_push, rx_pop, rx_flush, tx_flush, fifo_en, irq;
  logic dtr_out, rts_out, out1_out, out2_out;
  logic [7:0] tx_data, line_cfg;
  logic [1:0] rx_trig;
  logic [15:0] divisor;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_regbank uut (.*);

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rdchk(input logic [2:0] a, input logic [7:0] exp, input string req);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    chk(req, {8'h00, rdata}, {8'h00, exp});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 irq", {15'h0, irq}, 16'h0);
    chk("R1 divisor", divisor, 16'h0);
    chk("R1 line_cfg", {8'h0, line_cfg}, 16'h0);
    rdchk(3'd1, 8'h00, "R1 IER");
    rdchk(3'd2, 8'h01, "R1 IIR");
    rdchk(3'd4, 8'h00, "R1 MCR");
    rdchk(3'd5, 8'h60, "R1 LSR");
    rdchk(3'd6, 8'h00, "R1 MSR");

    // R2 R3 R4 R8 table walk
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][19]) rdchk(VEC[i][18:16], VEC[i][7:0], $sformatf("R2 vector %0d", i));
      else            wr(VEC[i][18:16], VEC[i][15:8]);
    end
    chk("R3 divisor bytes", divisor, 16'h010C);
    chk("R2 line_cfg", {8'h0, line_cfg}, 16'h001B);

    // R5 data strobes
    wr(3'd0, 8'h5A);
    chk("R5 push", {15'h0, tx_push}, 16'h1);
    chk("R5 data", {8'h0, tx_data}, 16'h005A);
    tick();
    chk("R5 push one cycle", {15'h0, tx_push}, 16'h0);
    rdchk(3'd0, 8'hA5, "R5 rx byte");
    chk("R5 pop", {15'h0, rx_pop}, 16'h1);
    wr(3'd3, 8'h9B);
    wr(3'd0, 8'h77);
    chk("R3 no push with divisor access", {15'h0, tx_push}, 16'h0);
    chk("R3 low divisor", divisor, 16'h0177);
    wr(3'd3, 8'h1B);

    // R6 FIFO control
    wr(3'd2, 8'h87);
    chk("R6 flush rx", {15'h0, rx_flush}, 16'h1);
    chk("R6 flush tx", {15'h0, tx_flush}, 16'h1);
    chk("R6 trig", {14'h0, rx_trig}, 16'h2);
    tick();
    chk("R6 flush self clear", {14'h0, rx_flush, tx_flush}, 16'h0);
    chk("R6 fifo_en", {15'h0, fifo_en}, 16'h1);
    rdchk(3'd2, 8'hC1, "R6 IIR marks");
    wr(3'd2, 8'h00);

    // R7 line status
    rx_parity_err = 1; tick(); rx_parity_err = 0;
    rdchk(3'd5, 8'h64, "R7 parity sticky");
    rdchk(3'd5, 8'h60, "R7 cleared by read");
    rx_frame_err = 1;
    rdchk(3'd5, 8'h60, "R7 same-cycle read");
    rx_frame_err = 0;
    rdchk(3'd5, 8'h68, "R7 same-cycle pulse kept");
    rdchk(3'd5, 8'h60, "R7 cleared again");
    rx_fifo_err = 1;
    rdchk(3'd5, 8'h60, "R7 fifo err hidden");
    wr(3'd2, 8'h01);
    rdchk(3'd5, 8'hE0, "R7 fifo err shown");
    rx_fifo_err = 0;
    wr(3'd2, 8'h00);

    // R8 R12 priority and gating
    wr(3'd1, 8'h0F);
    rx_valid = 1; rx_overrun = 1; tick(); rx_overrun = 0;
    rdchk(3'd2, 8'h06, "R8 line highest");
    chk("R12 masked by OUT2", {15'h0, irq}, 16'h0);
    wr(3'd4, 8'h0B); tick();
    chk("R12 irq asserted", {15'h0, irq}, 16'h1);
    rdchk(3'd5, 8'h63, "R7 overrun with data");
    rdchk(3'd2, 8'h04, "R8 rx data");
    rx_valid = 0;
    rdchk(3'd2, 8'h02, "R8 thr empty");
    rdchk(3'd2, 8'h01, "R9 cleared by IIR read");
    tick();
    chk("R12 irq drops", {15'h0, irq}, 16'h0);
    cts_in = 1; tick();
    rdchk(3'd2, 8'h00, "R8 modem lowest");
    chk("R12 modem irq", {15'h0, irq}, 16'h1);
    rdchk(3'd6, 8'h11, "R10 cts delta");
    rdchk(3'd2, 8'h01, "R10 delta cleared");
    cts_in = 0; tick();
    rdchk(3'd6, 8'h01, "R10 cts fall");
    wr(3'd2, 8'h01);
    rx_valid = 1;
    rdchk(3'd2, 8'hC1, "R8 fifo uses trigger");
    rx_trig_hit = 1;
    rdchk(3'd2, 8'hC4, "R8 trigger reached");
    rx_valid = 0; rx_trig_hit = 0;
    wr(3'd2, 8'h00);
    wr(3'd4, 8'h03);

    // R9 holding-empty source
    tx_hold_empty = 0; tick(); tx_hold_empty = 1; tick();
    rdchk(3'd2, 8'h02, "R9 rise sets");
    wr(3'd0, 8'h42);
    rdchk(3'd2, 8'h01, "R9 write clears");
    wr(3'd1, 8'h0D);
    wr(3'd1, 8'h0F);
    rdchk(3'd2, 8'h02, "R9 enable rearms");
    rdchk(3'd2, 8'h01, "R9 read clears");

    // R10 modem changes
    ri_in = 1; tick();
    rdchk(3'd6, 8'h40, "R10 ri rise no flag");
    ri_in = 0; tick();
    rdchk(3'd6, 8'h04, "R10 ri trailing edge");
    rdchk(3'd6, 8'h00, "R10 cleared");
    dsr_in = 1; tick();
    rdchk(3'd6, 8'h22, "R10 dsr change");
    dsr_in = 0; tick();
    rdchk(3'd6, 8'h02, "R10 dsr drop");

    // R11 loopback
    wr(3'd4, 8'h1A);
    chk("R11 outputs quiet", {12'h0, dtr_out, rts_out, out1_out, out2_out}, 16'h0);
    rdchk(3'd6, 8'h90, "R11 loop 0x1A");
    rdchk(3'd6, 8'h99, "R11 deltas after same-cycle read");
    rdchk(3'd6, 8'h90, "R11 deltas cleared");
    wr(3'd4, 8'h11);
    rdchk(3'd6, 8'h20, "R11 dtr to dsr");
    wr(3'd4, 8'h03);
    chk("R11 outputs back", {12'h0, dtr_out, rts_out, out1_out, out2_out}, 16'hC);
    rdchk(3'd6, 8'h0B, "R11 exit deltas");
    rdchk(3'd6, 8'h02, "R11 exit dsr drop");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule